// File: doc/BRIEF.md
# Bus-Attached Countdown Timer

A 32-bit down-counter with four word-wide registers on a simple register bus: a general-purpose scratch word, a control word, a reload value and a read-only view of the live count. Software sets the run bit to start counting. Each qualified tick then lowers the count by one. When the count reaches zero, it waits there for one tick. If the reload-and-interrupt bit is set, it then takes the reload value again. Otherwise it stays at zero.

The interrupt line is a level. It is high whenever the count is zero and the reload-and-interrupt bit is set. The run bit does not affect it. Software clears the interrupt by clearing that bit or by moving the count away from zero. The `tick_en` input qualifies each step. Tied high, it gives one step per clock.

The bus has separate read and write strobes, a byte address and a size code. Read data and the error flag are registered and appear one cycle after the access. Any access that is not a full word, does not fall on one of the four register offsets, or writes the count view is refused with the error flag.

Top module: `cdt_timer`

## Requirements
- R1: After reset the scratch, control, reload and count values are all zero, `irq` is low and `bus_err` is low.
- R2: Writes of a full word (size code 2) to offset 0x0 (scratch), 0x4 (control) or 0x8 (reload) store all 32 bits. Reads of those offsets return the stored value.
- R3: The count changes only on a cycle where `tick_en` is high and control bit 2 (run) is set. Otherwise the count holds.
- R4: On a qualified tick, a nonzero count drops by exactly one. After a control write that sets the run bit, the first step happens on the next qualified tick.
- R5: On a qualified tick, a zero count loads the reload value if control bit 0 (auto) is set. If bit 0 is clear, the count stays at zero.
- R6: `irq` is high exactly when the count is zero and control bit 0 is set, whether the run bit is set or not.
- R7: Offset 0xC reads the current count. A write to 0xC raises `bus_err` and leaves the count unchanged.
- R8: An access with a size code other than 2, or with an address other than 0x0, 0x4, 0x8 or 0xC, raises `bus_err`. Such a write changes no register.
- R9: A control or reload write in the same cycle as a qualified tick does not affect that tick. The tick uses the register values from before the write.
- R10: `bus_rdata` and `bus_err` are registered. They present the result of an access in the cycle after the strobe. Read data is zero when the read is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Qualifies one count step |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Byte address of the register |
| bus_size | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 reserved |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Registered access error |
| irq | output | 1 | Level interrupt: count at zero with auto bit set |

## Verification
The bench steps the counter one tick at a time, so it can see the hold at zero before the reload. A design that reloads on the same tick that reaches zero would skip that hold and show the reload value one tick early. It checks `irq` while the timer is stopped. A design that gated the interrupt with the run bit would stay silent there. It lands control and reload writes on the same cycle as a tick. A design that let the new values leak into that tick would reload the new period or miss the final decrement. It also sends refused writes: a write to the count view, a byte-sized write and a misaligned address. A design that let any of them through would show a changed register on readback.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
    localparam int CDT_DATA_W = 32;
    localparam int CDT_ADDR_W = 4;

    localparam logic [3:0] OFF_SCRATCH = 4'h0;
    localparam logic [3:0] OFF_CTRL    = 4'h4;
    localparam logic [3:0] OFF_RELOAD  = 4'h8;
    localparam logic [3:0] OFF_COUNT   = 4'hC;

    localparam int CTRL_AUTO_BIT = 0;
    localparam int CTRL_RUN_BIT  = 2;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;
endpackage

// File: rtl/cdt_regs.sv
module cdt_regs
    import cdt_pkg::*;
#(
    parameter int DATA_W = CDT_DATA_W,
    parameter int ADDR_W = CDT_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] count_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              err_o,
    output logic [DATA_W-1:0] ctrl_o,
    output logic [DATA_W-1:0] reload_o
);
    typedef struct packed {
        logic [DATA_W-1:0] scratch;
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] reload;
        logic [DATA_W-1:0] rdata;
        logic              err;
    } regs_t;

    regs_t r_d, r_q;

    logic hit_scr, hit_ctl, hit_rld, hit_cnt, hit_any, bad, wr_ok, rd_ok;

    always_comb begin
        hit_scr = (addr_i == ADDR_W'(OFF_SCRATCH));
        hit_ctl = (addr_i == ADDR_W'(OFF_CTRL));
        hit_rld = (addr_i == ADDR_W'(OFF_RELOAD));
        hit_cnt = (addr_i == ADDR_W'(OFF_COUNT));
        hit_any = hit_scr | hit_ctl | hit_rld | hit_cnt;
        bad     = (wr_i | rd_i) &&
                  ((size_i != SZ_WORD) || !hit_any || (wr_i && hit_cnt));
        wr_ok   = wr_i && !bad;
        rd_ok   = rd_i && !bad;

        r_d       = r_q;
        r_d.err   = bad;
        r_d.rdata = '0;
        if (wr_ok && hit_scr) r_d.scratch = wdata_i;
        if (wr_ok && hit_ctl) r_d.ctrl    = wdata_i;
        if (wr_ok && hit_rld) r_d.reload  = wdata_i;
        if (rd_ok) begin
            if (hit_scr)      r_d.rdata = r_q.scratch;
            else if (hit_ctl) r_d.rdata = r_q.ctrl;
            else if (hit_rld) r_d.rdata = r_q.reload;
            else              r_d.rdata = count_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rdata_o  = r_q.rdata;
    assign err_o    = r_q.err;
    assign ctrl_o   = r_q.ctrl;
    assign reload_o = r_q.reload;

    assert_cnt_write_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ADDR_W'(OFF_COUNT)) |=> err_o);

    assert_bad_size_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_i || rd_i) && size_i != SZ_WORD) |=>
        (err_o && $stable(ctrl_o) && $stable(reload_o) && $stable(r_q.scratch)));
endmodule

// File: rtl/cdt_count.sv
module cdt_count
    import cdt_pkg::*;
#(
    parameter int DATA_W = CDT_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              run_i,
    input  logic              auto_i,
    input  logic [DATA_W-1:0] reload_i,
    output logic [DATA_W-1:0] count_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [DATA_W-1:0] cnt;
    } cnt_t;

    cnt_t c_d, c_q;
    logic step;

    always_comb begin
        step = tick_en && run_i;
        c_d  = c_q;
        if (step) begin
            if (c_q.cnt != '0) c_d.cnt = c_q.cnt - DATA_W'(1);
            else if (auto_i)   c_d.cnt = reload_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign count_o = c_q.cnt;
    assign irq_o   = (c_q.cnt == '0) && auto_i;

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_en && run_i) |=> count_o == $past(count_o));

    assert_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && run_i && count_o != '0) |=> count_o == $past(count_o) - DATA_W'(1));

    assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && run_i && count_o == '0 && auto_i) |=> count_o == $past(reload_i));
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
    import cdt_pkg::*;
#(
    parameter int DATA_W = CDT_DATA_W,
    parameter int ADDR_W = CDT_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic              irq
);
    logic [DATA_W-1:0] ctrl_w, reload_w, count_w;

    cdt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (bus_wr),
        .rd_i     (bus_rd),
        .addr_i   (bus_addr),
        .size_i   (bus_size),
        .wdata_i  (bus_wdata),
        .count_i  (count_w),
        .rdata_o  (bus_rdata),
        .err_o    (bus_err),
        .ctrl_o   (ctrl_w),
        .reload_o (reload_w)
    );

    cdt_count #(.DATA_W(DATA_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .run_i    (ctrl_w[CTRL_RUN_BIT]),
        .auto_i   (ctrl_w[CTRL_AUTO_BIT]),
        .reload_i (reload_w),
        .count_o  (count_w),
        .irq_o    (irq)
    );

    assert_irq_needs_auto_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ctrl_w[CTRL_AUTO_BIT] && count_w == '0));
endmodule

// File: tb/cdt_timer_tb.sv
module cdt_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    cdt_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .irq(irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d,
                      input logic [1:0] sz, input logic tk, output logic e);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz; tick_en = tk;
        @(negedge clk);
        bus_wr = 1'b0; bus_size = 2'd2; tick_en = 1'b0;
        e = bus_err;
    endtask

    task automatic rd(input logic [3:0] a, input logic [1:0] sz,
                      output logic [31:0] d, output logic e);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a; bus_size = sz;
        @(negedge clk);
        bus_rd = 1'b0; bus_size = 2'd2;
        d = bus_rdata; e = bus_err;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    task automatic chk_count(input string req, input logic [31:0] exp);
        logic [31:0] d; logic e;
        rd(4'hC, 2'd2, d, e);
        check(req, "count", d, exp);
    endtask

    task automatic t_reset;
        logic [31:0] d; logic e;
        check("R1", "irq after reset", {31'd0, irq}, 32'd0);
        check("R1", "err after reset", {31'd0, bus_err}, 32'd0);
        for (int a = 0; a < 4; a++) begin
            rd(4'(a * 4), 2'd2, d, e);
            check("R1", "register after reset", d, 32'd0);
            check("R10", "read err", {31'd0, e}, 32'd0);
        end
    endtask

    task automatic t_rw;
        logic [31:0] d; logic e;
        wr(4'h0, 32'hA5C3_1E7F, 2'd2, 1'b0, e);
        check("R2", "scratch write err", {31'd0, e}, 32'd0);
        rd(4'h0, 2'd2, d, e);  check("R2", "scratch", d, 32'hA5C3_1E7F);
        wr(4'h8, 32'h8000_0001, 2'd2, 1'b0, e);
        rd(4'h8, 2'd2, d, e);  check("R2", "reload", d, 32'h8000_0001);
        wr(4'h4, 32'hF0F0_0000, 2'd2, 1'b0, e);
        rd(4'h4, 2'd2, d, e);  check("R2", "control", d, 32'hF0F0_0000);
        check("R6", "irq with bit0 clear", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_auto;
        logic e;
        wr(4'h8, 32'd3, 2'd2, 1'b0, e);
        wr(4'h4, 32'h1, 2'd2, 1'b0, e);
        check("R6", "irq while stopped", {31'd0, irq}, 32'd1);
        ticks(2);
        chk_count("R3", 32'd0);
        wr(4'h4, 32'h5, 2'd2, 1'b0, e);
        repeat (3) @(negedge clk);
        chk_count("R3", 32'd0);
        ticks(1);
        chk_count("R5", 32'd3);
        check("R6", "irq after reload", {31'd0, irq}, 32'd0);
        ticks(1);
        chk_count("R4", 32'd2);
        ticks(2);
        chk_count("R4", 32'd0);
        check("R6", "irq at zero", {31'd0, irq}, 32'd1);
        ticks(1);
        chk_count("R5", 32'd3);
    endtask

    task automatic t_noauto;
        logic e;
        wr(4'h4, 32'h4, 2'd2, 1'b0, e);
        ticks(3);
        chk_count("R4", 32'd0);
        check("R6", "irq bit0 clear", {31'd0, irq}, 32'd0);
        ticks(2);
        chk_count("R5", 32'd0);
    endtask

    task automatic t_errors;
        logic [31:0] d; logic e;
        wr(4'h4, 32'h0, 2'd2, 1'b0, e);
        wr(4'h8, 32'd7, 2'd2, 1'b0, e);
        wr(4'h4, 32'h5, 2'd2, 1'b0, e);
        ticks(1);
        chk_count("R7", 32'd7);
        wr(4'hC, 32'd99, 2'd2, 1'b0, e);
        check("R7", "count write err", {31'd0, e}, 32'd1);
        chk_count("R7", 32'd7);
        wr(4'h8, 32'd55, 2'd0, 1'b0, e);
        check("R8", "byte write err", {31'd0, e}, 32'd1);
        rd(4'h8, 2'd2, d, e); check("R8", "reload after byte write", d, 32'd7);
        rd(4'h8, 2'd1, d, e);
        check("R8", "half read err", {31'd0, e}, 32'd1);
        check("R10", "refused read data", d, 32'd0);
        wr(4'h2, 32'hFFFF_FFFF, 2'd2, 1'b0, e);
        check("R8", "misaligned write err", {31'd0, e}, 32'd1);
        rd(4'h0, 2'd2, d, e); check("R8", "scratch after misaligned", d, 32'hA5C3_1E7F);
        rd(4'h4, 2'd2, d, e); check("R8", "control after misaligned", d, 32'h5);
        rd(4'h6, 2'd2, d, e);
        check("R8", "misaligned read err", {31'd0, e}, 32'd1);
    endtask

    task automatic t_same_cycle;
        logic e;
        ticks(7);
        chk_count("R9", 32'd0);
        wr(4'h8, 32'd9, 2'd2, 1'b1, e);
        chk_count("R9", 32'd7);
        wr(4'h4, 32'h1, 2'd2, 1'b1, e);
        chk_count("R9", 32'd6);
        ticks(2);
        chk_count("R3", 32'd6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rw();
        t_auto();
        t_noauto();
        t_errors();
        t_same_cycle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule